// File: doc/BRIEF.md
# SpaceWire link initialisation controller

This block is the state machine that brings a point-to-point serial link from reset to data exchange, keeps it running, and drops it back to reset on errors. It watches what the receiver has seen: NULLs, flow-control tokens (FCTs), normal data characters, end-of-packet markers, time-codes, receive errors and credit errors. From that it drives level enables that tell a transmitter which kinds of characters it may send, together with reset controls for the transmitter and the receiver.

Receiver events come from a foreign clock domain. Each event pulse sets a flag that can only be set, never cleared, by the event. The flag is cleared only while the controller sits in its error-reset state. A two-stage synchronizer brings the flags into the system clock domain. A single counter, restarted on every state change, provides the short (6.4 µs) and long (12.8 µs) protocol timeouts, given in clock cycles as `SHORT_CYC` and `LONG_CYC`.

Top module: `spw_link_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the error-reset state, `tx_rst_o` and `rx_rst_o` are 1 and all four send enables are 0. Between those two states the output patterns are as follows. Error-wait and ready give tx reset only. Started gives NULL only. Connecting gives NULL and FCT. Run gives all four enables.
- R2: Error-reset lasts exactly `SHORT_CYC` rising edges from its entry, or from reset release. It then moves to error-wait, which releases only the receiver.
- R3: Error-wait lasts `LONG_CYC` edges and then moves to ready. Ready holds until `link_en_i` is 1 and `link_dis_i` is 0, and moves to started on the next edge.
- R4: A pulse on an event input changes the state on the third rising edge after the pulse, and not before.
- R5: In started, a received NULL moves the link to connecting.
- R6: In connecting, a received FCT moves the link to run. In run, all four send enables are 1.
- R7: Started and connecting each fall back to error-reset after `LONG_CYC` edges if no advancing event arrives.
- R8: An FCT, a normal character, an end-of-packet or error-end marker, a time-code or a receive error received in error-wait, ready, started or connecting returns the link to error-reset. In connecting, an FCT advances the link instead.
- R9: In run, a credit error or a receive error returns the link to error-reset. In started, connecting or run, `link_dis_i` returns the link to error-reset on the next edge.
- R10: In run, normal characters, markers, time-codes, NULLs and FCTs leave all outputs unchanged.
- R11: Event flags are cleared throughout error-reset. Events seen before an error do not advance the link after it recovers.
- R12: A NULL received in error-wait is retained. Started then advances to connecting on the edge after it is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_en_i | input | 1 | Permission to start the link (system domain level) |
| link_dis_i | input | 1 | Forces the link down (system domain level) |
| got_null_i | input | 1 | Receiver saw a NULL (pulse, foreign domain) |
| got_fct_i | input | 1 | Receiver saw an FCT (pulse) |
| got_nchar_i | input | 1 | Receiver saw a data character (pulse) |
| got_eop_i | input | 1 | Receiver saw an end-of-packet marker (pulse) |
| got_eep_i | input | 1 | Receiver saw an error-end marker (pulse) |
| got_tcode_i | input | 1 | Receiver saw a time-code (pulse) |
| rx_err_i | input | 1 | Receiver detected a link error (pulse) |
| credit_err_i | input | 1 | Credit overflow detected (pulse) |
| send_null_o | output | 1 | Transmitter may send NULLs |
| send_fct_o | output | 1 | Transmitter may send FCTs |
| send_nchar_o | output | 1 | Transmitter may send data characters |
| send_tcode_o | output | 1 | Transmitter may send time-codes |
| tx_rst_o | output | 1 | Holds the transmitter in reset |
| rx_rst_o | output | 1 | Holds the receiver in reset |

## Verification
A receiver event pulse is raised and dropped inside one low clock phase. Its effect is due on the third rising edge: one edge for each synchronizer stage, then the state register. The bench samples two edges after the pulse to confirm nothing has moved yet, and one edge later for the new state. `link_dis_i` acts on the next edge. Every timeout is checked one edge before and exactly at its expiry, with the count taken from the entry edge of the state. All samples are taken on the falling clock edge.

// File: rtl/spw_link_ctrl.sv
module spw_link_ctrl #(
  parameter int SHORT_CYC   = 1600,
  parameter int LONG_CYC    = 3200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_en_i,
  input  logic link_dis_i,
  input  logic got_null_i,
  input  logic got_fct_i,
  input  logic got_nchar_i,
  input  logic got_eop_i,
  input  logic got_eep_i,
  input  logic got_tcode_i,
  input  logic rx_err_i,
  input  logic credit_err_i,
  output logic send_null_o,
  output logic send_fct_o,
  output logic send_nchar_o,
  output logic send_tcode_o,
  output logic tx_rst_o,
  output logic rx_rst_o
);
  localparam int NEV = 8;
  localparam int TW  = $clog2(LONG_CYC + 1);

  typedef enum logic [2:0] {
    S_ERR_RESET, S_ERR_WAIT, S_READY, S_STARTED, S_CONNECTING, S_RUN
  } st_t;

  st_t st_q, st_n;
  logic [TW-1:0] cnt_q;
  logic clr_q;

  logic [NEV-1:0] ev_raw, ev_flag, seen;
  logic [NEV-1:0] sync_q [SYNC_STAGES];

  assign ev_raw = {credit_err_i, rx_err_i, got_tcode_i, got_eep_i,
                   got_eop_i, got_nchar_i, got_fct_i, got_null_i};

  for (genvar g = 0; g < NEV; g++) begin : g_log
    logic flag_q;
    always_ff @(posedge ev_raw[g] or posedge clr_q) begin
      if (clr_q) flag_q <= 1'b0;
      else       flag_q <= 1'b1;
    end
    assign ev_flag[g] = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= ev_flag;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign seen = sync_q[SYNC_STAGES-1];

  wire seen_null  = seen[0];
  wire seen_fct   = seen[1];
  wire seen_data  = |seen[4:2];
  wire seen_tcode = seen[5];
  wire seen_rxerr = seen[6];
  wire seen_crerr = seen[7];
  wire premature  = seen_fct | seen_data | seen_tcode | seen_rxerr;

  wire t_short = (cnt_q == TW'(SHORT_CYC - 1));
  wire t_long  = (cnt_q == TW'(LONG_CYC - 1));

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      S_ERR_RESET:  if (t_short) st_n = S_ERR_WAIT;
      S_ERR_WAIT:   if (premature) st_n = S_ERR_RESET;
                    else if (t_long) st_n = S_READY;
      S_READY:      if (premature) st_n = S_ERR_RESET;
                    else if (link_en_i && !link_dis_i) st_n = S_STARTED;
      S_STARTED:    if (link_dis_i || premature || t_long) st_n = S_ERR_RESET;
                    else if (seen_null) st_n = S_CONNECTING;
      S_CONNECTING: if (link_dis_i || seen_data || seen_tcode || seen_rxerr || t_long)
                      st_n = S_ERR_RESET;
                    else if (seen_fct) st_n = S_RUN;
      S_RUN:        if (link_dis_i || seen_rxerr || seen_crerr) st_n = S_ERR_RESET;
      default:      st_n = S_ERR_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_ERR_RESET;
      cnt_q <= '0;
      clr_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      clr_q <= (st_n == S_ERR_RESET);
      if (st_n != st_q)  cnt_q <= '0;
      else if (!t_long)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rx_rst_o     = (st_q == S_ERR_RESET);
  assign tx_rst_o     = (st_q == S_ERR_RESET) || (st_q == S_ERR_WAIT) || (st_q == S_READY);
  assign send_null_o  = (st_q == S_STARTED) || (st_q == S_CONNECTING) || (st_q == S_RUN);
  assign send_fct_o   = (st_q == S_CONNECTING) || (st_q == S_RUN);
  assign send_nchar_o = (st_q == S_RUN);
  assign send_tcode_o = (st_q == S_RUN);
endmodule

// File: rtl/spw_link_ctrl_chk.sv
module spw_link_ctrl_chk #(
  parameter int SHORT_CYC = 1600
) (
  input logic clk_i,
  input logic rst_ni,
  input logic link_dis_i,
  input logic send_null_o,
  input logic send_fct_o,
  input logic send_nchar_o,
  input logic send_tcode_o,
  input logic tx_rst_o,
  input logic rx_rst_o
);
  localparam int HW = $clog2(SHORT_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_cnt <= '0;
    else if (rx_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  p_rx_follows_tx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rst_o |-> !rx_rst_o);

  p_reset_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_rst_o) |-> (hi_cnt == HW'(SHORT_CYC)));

  p_wait_keeps_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_rst_o) |-> tx_rst_o);

  p_start_after_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_rst_o) |-> !$past(rx_rst_o));

  p_run_all_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_nchar_o |-> (send_tcode_o && send_fct_o && send_null_o));

  p_run_from_conn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_nchar_o) |-> $past(send_fct_o));

  p_disable_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_null_o && link_dis_i) |=> (tx_rst_o && rx_rst_o));
endmodule

bind spw_link_ctrl spw_link_ctrl_chk #(.SHORT_CYC(SHORT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .link_dis_i(link_dis_i),
  .send_null_o(send_null_o), .send_fct_o(send_fct_o),
  .send_nchar_o(send_nchar_o), .send_tcode_o(send_tcode_o),
  .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o)
);

// File: tb/spw_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module spw_link_ctrl_tb_top;
  localparam int SH = 8;
  localparam int LG = 16;
  localparam logic [5:0] C_RST  = 6'b110000;
  localparam logic [5:0] C_WAIT = 6'b100000;
  localparam logic [5:0] C_STRT = 6'b001000;
  localparam logic [5:0] C_CONN = 6'b001100;
  localparam logic [5:0] C_RUN  = 6'b001111;

  logic clk = 0, rst_ni = 0, link_en = 0, link_dis = 0;
  logic [7:0] ev = '0;
  logic s_null, s_fct, s_nchar, s_tcode, tx_rst, rx_rst;
  int checks = 0, fails = 0;
  logic done = 0;

  always #2 clk = ~clk;

  spw_link_ctrl #(.SHORT_CYC(SH), .LONG_CYC(LG)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .link_en_i(link_en), .link_dis_i(link_dis),
    .got_null_i(ev[0]), .got_fct_i(ev[1]), .got_nchar_i(ev[2]), .got_eop_i(ev[3]),
    .got_eep_i(ev[4]), .got_tcode_i(ev[5]), .rx_err_i(ev[6]), .credit_err_i(ev[7]),
    .send_null_o(s_null), .send_fct_o(s_fct), .send_nchar_o(s_nchar),
    .send_tcode_o(s_tcode), .tx_rst_o(tx_rst), .rx_rst_o(rx_rst));

  wire [5:0] outs = {tx_rst, rx_rst, s_null, s_fct, s_nchar, s_tcode};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    ev[i] = 1'b1; #1; ev[i] = 1'b0;
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (outs !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, outs, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; ev = '0; link_dis = 0;
    step(2);
    rst_ni = 1;
  endtask

  task automatic to_wait();  link_en = 0; do_reset(); step(SH + 2); endtask
  task automatic to_ready(); link_en = 0; do_reset(); step(SH + LG + 2); endtask
  task automatic to_started(); link_en = 1; do_reset(); step(SH + LG + 1); endtask
  task automatic to_conn();  to_started(); pulse(0); step(3); endtask
  task automatic to_run();   to_conn(); pulse(1); step(3); endtask

  initial begin
    step(1);
    chk("R1 reset", C_RST);
    // R2 short timeout, R3 long timeout and ready
    link_en = 1; do_reset();
    step(SH - 1); chk("R2 still in error-reset", C_RST);
    step(1);      chk("R2 error-wait", C_WAIT);
    step(LG);     chk("R3 wait/ready", C_WAIT);
    step(1);      chk("R3 started", C_STRT);
    // R5 and R4 latency
    pulse(0);
    step(2);      chk("R4 no early move", C_STRT);
    step(1);      chk("R5 connecting", C_CONN);
    pulse(1);
    step(2);      chk("R4 no early move", C_CONN);
    step(1);      chk("R6 run", C_RUN);
    // R10 events ignored in run
    for (int e = 0; e < 6; e++) begin
      pulse(e); step(4); chk("R10 run unaffected", C_RUN);
    end
    // R9 credit error, R11 flags cleared
    pulse(7);
    step(2); chk("R9 run before credit error lands", C_RUN);
    step(1); chk("R9 credit error", C_RST);
    step(SH + LG + 1); chk("R11 restart to started", C_STRT);
    step(3); chk("R11 stale null not used", C_STRT);
    // R7 started timeout (entered SH+LG+1 edges after error entry; 3 used)
    step(LG - 4); chk("R7 started before timeout", C_STRT);
    step(1);      chk("R7 started timeout", C_RST);
    // R7 connecting timeout
    to_conn();
    step(LG - 1); chk("R7 connecting before timeout", C_CONN);
    step(1);      chk("R7 connecting timeout", C_RST);
    // R9 receive error in run, link disable
    to_run(); pulse(6); step(3); chk("R9 rx error in run", C_RST);
    to_run(); link_dis = 1; step(1); chk("R9 disable in run", C_RST); link_dis = 0;
    to_conn(); link_dis = 1; step(1); chk("R9 disable in connecting", C_RST); link_dis = 0;
    to_started(); link_dis = 1; step(1); chk("R9 disable in started", C_RST); link_dis = 0;
    // R3 ready waits for enable, disable blocks start
    to_ready();
    step(20); chk("R3 ready holds", C_WAIT);
    link_dis = 1; link_en = 1; step(3); chk("R3 disable blocks start", C_WAIT);
    link_dis = 0; step(1); chk("R3 start on enable", C_STRT);
    // R12 null retained from error-wait
    link_en = 1; do_reset(); step(SH + 2); pulse(0);
    step(LG - 1); chk("R12 started entered", C_STRT);
    step(1);      chk("R12 immediate connecting", C_CONN);
    // R8 premature events sweep
    for (int s = 0; s < 4; s++) begin
      for (int e = 1; e < 7; e++) begin
        if (!(s == 3 && e == 1)) begin
          logic [5:0] here;
          case (s)
            0: begin to_wait();    here = C_WAIT; end
            1: begin to_ready();   here = C_WAIT; end
            2: begin to_started(); here = C_STRT; end
            default: begin to_conn(); here = C_CONN; end
          endcase
          pulse(e);
          step(2); chk("R8 before reaction", here);
          step(1); chk("R8 premature event", C_RST);
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: outputs=%b expected=finished", outs);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule